// File: doc/BRIEF.md
# Pipeline Interlock and Forwarding Controller

This block resolves read-after-write hazards for a six-stage scalar in-order pipeline. The stages are fetch, decode, register read, execute, memory and writeback. The instruction in the register-read stage has two source register specifiers. The block compares each of them with the destination specifiers of the two instructions ahead of it, one in execute and one in memory. For each source it chooses where the operand comes from: the register file, the execute-stage result, or the memory-stage value. The memory-stage value is the loaded data for a load and the carried execute result otherwise. A producer three instructions ahead needs no logic here, because the register file writes before it reads in the same cycle.

A load in execute cannot supply its value to the instruction directly behind it. When such a load-use dependence is seen, the controller asserts `stall` to freeze fetch, decode and register read for one cycle. It also asserts `bubble`, so that an instruction with its write-enable and load flag cleared enters execute. On the next cycle the load has reached memory, and its data is forwarded from there.

A two-state machine sequences the stall. In state ST_RUN the block forwards normally, and a load-use dependence takes the transition RUN_TO_HOLD while it asserts `stall` and `bubble`. State ST_HOLD lasts exactly one cycle: it always takes HOLD_TO_RUN and never stalls. When no load-use dependence is seen, ST_RUN takes RUN_STAY. Reset enters ST_RUN.

Top module: `hz_interlock`

## Requirements
- R1: A source with no qualifying match in execute or memory gets forwarding select 2'b00, meaning the register file.
- R2: A source equal to the execute-stage destination, with execute write-enable high and execute load flag low, gets select 2'b01, meaning the execute-stage result.
- R3: A source equal to the memory-stage destination, with memory write-enable high, and with no R2 match, gets select 2'b10, meaning the memory-stage value.
- R4: When a source matches both execute and memory under R2 and R3, the younger execute-stage producer wins and the select is 2'b01.
- R5: Source register 0 never forwards and never stalls, whatever the destinations are.
- R6: A stage whose write-enable is low never causes forwarding or a stall.
- R7: When the execute stage holds a load (write-enable high, load flag high) and either source matches its nonzero destination, `stall` and `bubble` are both high in that cycle.
- R8: A source that matches an execute-stage load never selects 2'b01. It takes 2'b10 if memory also matches, and 2'b00 otherwise.
- R9: `stall` is never high on two consecutive cycles. The cycle after a stall is ST_HOLD, where `stall` and `bubble` stay low even if the inputs still show a load-use dependence.
- R10: After reset the machine is in ST_RUN. With idle inputs all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_src_a | input | 5 | First source specifier in register read |
| rd_src_b | input | 5 | Second source specifier in register read |
| ex_dst | input | 5 | Destination specifier in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | 5 | Destination specifier in memory |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| fwd_a | output | 2 | Operand select for source A |
| fwd_b | output | 2 | Operand select for source B |
| stall | output | 1 | Freeze fetch, decode and register read |
| bubble | output | 1 | Insert a null instruction into execute |

## Verification
A vector table first covers each kind of match in isolation: none, execute only, memory only, both stages, register 0, write-enable low, and a load in execute. Each vector separates one priority or qualification rule from the others. Load-use vectors are repeated back to back, so the bench can tell a correct single-cycle hold from a stall that persists. A random stream over a small register range then creates dependences at distances 1 to 3 in every mix. A scoreboard that models the one-cycle hold predicts the selects and the stall for every cycle of it.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_REG = 2'b00,
        FWD_ALU = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } stall_st_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    output fwd_sel_e      sel,
    output logic          load_hit
);
    logic src_live;
    logic ex_hit;
    logic mem_hit;

    always_comb begin
        src_live = (src != '0);
        ex_hit   = src_live && ex_wr && (ex_dst == src);
        mem_hit  = src_live && mem_wr && (mem_dst == src);
        load_hit = ex_hit && ex_load;
        if (ex_hit && !ex_load)
            sel = FWD_ALU;
        else if (mem_hit)
            sel = FWD_MEM;
        else
            sel = FWD_REG;
    end

    assert_zero_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == FWD_REG && !load_hit));

    assert_alu_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src != '0 && ex_wr && !ex_load && ex_dst == src && mem_wr && mem_dst == src)
        |-> (sel == FWD_ALU));

    assert_load_not_alu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |-> (sel != FWD_ALU));
endmodule

// File: rtl/hz_stall_fsm.sv
module hz_stall_fsm
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall,
    output logic bubble
);
    stall_st_e state_q;
    stall_st_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        bubble  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hazard) begin
                    stall   = 1'b1;
                    bubble  = 1'b1;
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    assert_stall_from_hazard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || bubble) |-> hazard);
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_src_a,
    input  logic [AW-1:0] rd_src_b,
    input  logic [AW-1:0] ex_dst,
    input  logic          ex_wr,
    input  logic          ex_load,
    input  logic [AW-1:0] mem_dst,
    input  logic          mem_wr,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          stall,
    output logic          bubble
);
    localparam int NSRC = 2;

    logic [AW-1:0] srcs [NSRC];
    fwd_sel_e      sels [NSRC];
    logic [NSRC-1:0] load_hits;

    assign srcs[0] = rd_src_a;
    assign srcs[1] = rd_src_b;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        hz_src_match #(.AW(AW)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .src      (srcs[i]),
            .ex_dst   (ex_dst),
            .ex_wr    (ex_wr),
            .ex_load  (ex_load),
            .mem_dst  (mem_dst),
            .mem_wr   (mem_wr),
            .sel      (sels[i]),
            .load_hit (load_hits[i])
        );
    end

    assign fwd_a = sels[0];
    assign fwd_b = sels[1];

    hz_stall_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (|load_hits),
        .stall  (stall),
        .bubble (bubble)
    );

    assert_we_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_wr && !mem_wr) |-> (fwd_a == 2'b00 && fwd_b == 2'b00 && !stall));

    assert_stall_needs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (ex_wr && ex_load && ex_dst != '0));
endmodule

// File: tb/sim_hz_interlock.sv
module sim_hz_interlock;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] rs1 = '0, rs2 = '0, ard = '0, mrd = '0;
    logic awe = 1'b0, ald = 1'b0, mwe = 1'b0;
    logic [1:0] fa, fb;
    logic st, bb;
    int checks = 0;
    int errors = 0;
    logic prev_stall = 1'b0;

    always #2.5 clk = ~clk;

    hz_interlock u0 (
        .clk(clk), .rst_n(rst_n), .rd_src_a(rs1), .rd_src_b(rs2),
        .ex_dst(ard), .ex_wr(awe), .ex_load(ald), .mem_dst(mrd), .mem_wr(mwe),
        .fwd_a(fa), .fwd_b(fb), .stall(st), .bubble(bb)
    );

    // rs1,rs2,ard,awe,ald,mrd,mwe,exp_a,exp_b,exp_stall  (28 bits)
    localparam int NV = 13;
    localparam logic [27:0] VEC [NV] = '{
        {5'd1, 5'd2, 5'd3, 1'b1,1'b0, 5'd4, 1'b1, 2'd0,2'd0,1'b0},  // R1
        {5'd3, 5'd2, 5'd3, 1'b1,1'b0, 5'd4, 1'b1, 2'd1,2'd0,1'b0},  // R2
        {5'd1, 5'd4, 5'd3, 1'b1,1'b0, 5'd4, 1'b1, 2'd0,2'd2,1'b0},  // R3
        {5'd5, 5'd5, 5'd5, 1'b1,1'b0, 5'd5, 1'b1, 2'd1,2'd1,1'b0},  // R4
        {5'd0, 5'd0, 5'd0, 1'b1,1'b0, 5'd0, 1'b1, 2'd0,2'd0,1'b0},  // R5
        {5'd6, 5'd7, 5'd6, 1'b0,1'b0, 5'd7, 1'b0, 2'd0,2'd0,1'b0},  // R6
        {5'd8, 5'd9, 5'd8, 1'b1,1'b1, 5'd9, 1'b1, 2'd0,2'd2,1'b1},  // R7 R8
        {5'd8, 5'd9, 5'd8, 1'b1,1'b1, 5'd9, 1'b1, 2'd0,2'd2,1'b0},  // R9 hold
        {5'd10,5'd11,5'd12,1'b1,1'b1, 5'd10,1'b1, 2'd2,2'd0,1'b0},  // R3
        {5'd12,5'd12,5'd12,1'b1,1'b1, 5'd12,1'b1, 2'd2,2'd2,1'b1},  // R8
        {5'd13,5'd0, 5'd0, 1'b1,1'b1, 5'd13,1'b1, 2'd2,2'd0,1'b0},  // R5
        {5'd14,5'd15,5'd15,1'b0,1'b1, 5'd0, 1'b1, 2'd0,2'd0,1'b0},  // R6
        {5'd16,5'd17,5'd17,1'b1,1'b1, 5'd0, 1'b1, 2'd0,2'd0,1'b1}   // R7
    };

    function automatic logic [1:0] ref_sel(input logic [4:0] s);
        if (s == 0) return 2'd0;
        if (awe && !ald && ard == s) return 2'd1;
        if (mwe && mrd == s) return 2'd2;
        return 2'd0;
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_cycle(input string tag, input logic [1:0] ea, input logic [1:0] eb,
                             input logic es);
        chk({tag, " fwd_a"}, {3'b0, fa}, {3'b0, ea});
        chk({tag, " fwd_b"}, {3'b0, fb}, {3'b0, eb});
        chk({tag, " stall"}, {4'b0, st}, {4'b0, es});
        chk({tag, " bubble"}, {4'b0, bb}, {4'b0, es});
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk_cycle("R10 reset idle", 2'd0, 2'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk); #1;
            {rs1, rs2, ard, awe, ald, mrd, mwe} = VEC[i][27:5];
            @(negedge clk);
            chk_cycle($sformatf("table row %0d", i), VEC[i][4:3], VEC[i][2:1], VEC[i][0]);
        end

        // R9: reset returns to RUN so a load-use right after reset stalls
        @(posedge clk); #1;
        rst_n = 1'b0;
        rs1 = 5'd20; rs2 = 5'd1; ard = 5'd20; awe = 1'b1; ald = 1'b1; mwe = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk_cycle("R10 R7 stall after reset", 2'd0, 2'd0, 1'b1);
        prev_stall = 1'b1;

        // random scoreboard stream, registers 0..3 for frequent dependences
        for (int n = 0; n < 2000; n++) begin
            logic es;
            @(posedge clk); #1;
            rs1 = 5'($urandom_range(0, 3)); rs2 = 5'($urandom_range(0, 3));
            ard = 5'($urandom_range(0, 3)); mrd = 5'($urandom_range(0, 3));
            awe = 1'($urandom_range(0, 1)); ald = 1'($urandom_range(0, 1));
            mwe = 1'($urandom_range(0, 1));
            es = !prev_stall && awe && ald &&
                 ((rs1 != 0 && rs1 == ard) || (rs2 != 0 && rs2 == ard));
            @(negedge clk);
            chk_cycle("R1 R2 R3 R4 R8 R9 random", ref_sel(rs1), ref_sel(rs2), es);
            prev_stall = es;
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule